// File: doc/BRIEF.md
# Block-Skipping Window Scanner

This block walks a byte text buffer with a window `WIN` bytes wide and decides, for each window position, how far the window may jump without missing a pattern occurrence. The last two bytes of the window are folded into a 12-bit index. The index selects an entry in a programmable shift table. A non-zero entry moves the window forward by that many bytes. A zero entry means the window may end in a pattern. The block then reports the window start as a candidate for exact checking, done elsewhere, and moves forward by one byte.

Software first loads the text through the text write port and the shift values through the table write port. The table is built offline. Where several blocks share an index, the entry holds the smallest of their shift values. Software then pulses `start` with the text length on `txt_len`. The block raises `busy`, emits one `cand_valid` pulse for each zero-shift window, and ends with a single-cycle `done` pulse.

Top module: `wsk_scanner`

## Requirements
- R1: After reset `busy`, `done` and `cand_valid` are all 0.
- R2: For a window starting at byte p, the table index is ((text[p+WIN-2] << 4) XOR text[p+WIN-1]) taken to 12 bits. With the default WIN=8 these are bytes p+6 and p+7.
- R3: When the indexed entry holds a non-zero value s, the next window starts at p+s and no candidate is reported.
- R4: When the indexed entry is zero, `cand_valid` pulses for one cycle with `cand_pos` = p, and the next window starts at p+1.
- R5: The scan begins at p=0. It ends as soon as p+WIN exceeds the sampled length: `done` then pulses for exactly one cycle and `busy` returns to 0. A length below WIN gives no window step at all.
- R6: Each window step takes exactly two clock cycles. With N steps, `done` is high after the clock edge that comes 2N+1 edges after the edge that samples `start`.
- R7: `start` and `txt_len` are ignored while `busy` is 1. The candidate list and the timing of `done` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txt_we | input | 1 | Text buffer write enable |
| txt_waddr | input | 8 | Text buffer write address |
| txt_wdata | input | 8 | Text byte to write |
| tab_we | input | 1 | Shift table write enable |
| tab_waddr | input | 12 | Shift table entry index |
| tab_wdata | input | 4 | Shift value to store |
| start | input | 1 | Begin a scan (sampled when idle) |
| txt_len | input | 9 | Number of valid text bytes, sampled with start |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at the end of a scan |
| cand_valid | output | 1 | One-cycle pulse for a zero-shift window |
| cand_pos | output | 8 | Start byte of the candidate window |

## Verification
The assertions assume that neither the text buffer nor the shift table is written while `busy` is high. They also assume that `txt_len` never exceeds the buffer depth. Under those conditions the stepping rules hold. The stimulus loads all text and every table entry before each `start`. It keeps lengths between 0 and 256. During a scan it changes only `start` and `txt_len`, which the block must ignore.

// File: rtl/wsk_pkg.sv
package wsk_pkg;
  parameter int CHAR_W = 8;
  parameter int IDX_W  = 12;
  parameter int SH_W   = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_LOOK} wsk_state_e;

  // R2: fold two block bytes into a table index
  function automatic logic [IDX_W-1:0] block_index(input logic [CHAR_W-1:0] prev,
                                                   input logic [CHAR_W-1:0] last);
    logic [IDX_W-1:0] hi;
    logic [IDX_W-1:0] lo;
    hi = IDX_W'(prev) << (IDX_W - CHAR_W);
    lo = IDX_W'(last);
    return hi ^ lo;
  endfunction

  // R3/R4: jump distance for a table value (zero forces a one-byte step)
  function automatic logic [SH_W:0] jump_of(input logic [SH_W-1:0] sh);
    return (sh == '0) ? (SH_W+1)'(1) : {1'b0, sh};
  endfunction
endpackage

// File: rtl/wsk_text_buf.sv
module wsk_text_buf #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic [AW-1:0] raddr_prev,
  input  logic [AW-1:0] raddr_last,
  output logic [DW-1:0] q_prev,
  output logic [DW-1:0] q_last
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (rd_en) begin
      q_prev <= mem[raddr_prev];
      q_last <= mem[raddr_last];
    end
  end
endmodule

// File: rtl/wsk_shift_tab.sv
module wsk_shift_tab #(
  parameter int IW = 12,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [SW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [SW-1:0] shift
);
  localparam int DEPTH = 1 << IW;
  logic [SW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign shift = mem[raddr];
endmodule

// File: rtl/wsk_scan_ctrl.sv
module wsk_scan_ctrl
  import wsk_pkg::*;
#(
  parameter int WIN  = 8,
  parameter int TA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [TA_W:0]   len,
  input  logic [SH_W-1:0] shift,
  output logic            fetch_en,
  output logic [TA_W-1:0] addr_prev,
  output logic [TA_W-1:0] addr_last,
  output logic            busy,
  output logic            done,
  output logic            cand_valid,
  output logic [TA_W-1:0] cand_pos
);
  localparam int LEN_W = TA_W + 1;
  localparam int POS_W = TA_W + 2;

  wsk_state_e       st;
  logic [POS_W-1:0] pos;
  logic [LEN_W-1:0] len_q;
  logic             win_past_end;
  logic             step_fire;
  logic             zero_hit;
  logic [POS_W-1:0] end_excl;

  assign end_excl     = pos + POS_W'(WIN);
  assign win_past_end = end_excl > POS_W'(len_q);
  assign step_fire    = (st == ST_LOOK);
  assign zero_hit     = step_fire && (shift == '0);
  assign fetch_en     = (st == ST_FETCH);
  assign addr_prev    = TA_W'(pos + POS_W'(WIN - 2));
  assign addr_last    = TA_W'(pos + POS_W'(WIN - 1));
  assign busy         = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      pos        <= '0;
      len_q      <= '0;
      done       <= 1'b0;
      cand_valid <= 1'b0;
      cand_pos   <= '0;
    end else begin
      done       <= 1'b0;
      cand_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          pos   <= '0;
          len_q <= len;
          st    <= ST_FETCH;
        end
        ST_FETCH: begin
          if (win_past_end) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            st <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (zero_hit) begin
            cand_valid <= 1'b1;
            cand_pos   <= TA_W'(pos);
          end
          pos <= pos + POS_W'(jump_of(shift));
          st  <= ST_FETCH;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!busy && !done && !cand_valid));

  p_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && shift != '0) |=> (pos == $past(pos) + POS_W'($past(shift)) && !cand_valid));

  p_zero_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> (cand_valid && cand_pos == TA_W'($past(pos)) && pos == $past(pos) + 1'b1));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_look_returns_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> (st == ST_FETCH));

  p_len_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(len_q));
endmodule

// File: rtl/wsk_scanner.sv
module wsk_scanner
  import wsk_pkg::*;
#(
  parameter int WIN  = 8,
  parameter int TA_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txt_we,
  input  logic [TA_W-1:0]  txt_waddr,
  input  logic [CHAR_W-1:0] txt_wdata,
  input  logic             tab_we,
  input  logic [IDX_W-1:0] tab_waddr,
  input  logic [SH_W-1:0]  tab_wdata,
  input  logic             start,
  input  logic [TA_W:0]    txt_len,
  output logic             busy,
  output logic             done,
  output logic             cand_valid,
  output logic [TA_W-1:0]  cand_pos
);
  logic              fetch_en;
  logic [TA_W-1:0]   addr_prev;
  logic [TA_W-1:0]   addr_last;
  logic [CHAR_W-1:0] byte_prev;
  logic [CHAR_W-1:0] byte_last;
  logic [IDX_W-1:0]  tab_idx;
  logic [SH_W-1:0]   shift_val;

  assign tab_idx = block_index(byte_prev, byte_last);

  wsk_text_buf #(.AW(TA_W), .DW(CHAR_W)) u_text (
    .clk(clk), .we(txt_we), .waddr(txt_waddr), .wdata(txt_wdata),
    .rd_en(fetch_en), .raddr_prev(addr_prev), .raddr_last(addr_last),
    .q_prev(byte_prev), .q_last(byte_last)
  );

  wsk_shift_tab #(.IW(IDX_W), .SW(SH_W)) u_tab (
    .clk(clk), .we(tab_we), .waddr(tab_waddr), .wdata(tab_wdata),
    .raddr(tab_idx), .shift(shift_val)
  );

  wsk_scan_ctrl #(.WIN(WIN), .TA_W(TA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .len(txt_len), .shift(shift_val),
    .fetch_en(fetch_en), .addr_prev(addr_prev), .addr_last(addr_last),
    .busy(busy), .done(done), .cand_valid(cand_valid), .cand_pos(cand_pos)
  );

  p_no_write_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!txt_we && !tab_we));
endmodule

// File: tb/sim_wsk_scanner.sv
module sim_wsk_scanner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txt_we = 1'b0;
  logic [7:0]  txt_waddr = '0;
  logic [7:0]  txt_wdata = '0;
  logic        tab_we = 1'b0;
  logic [11:0] tab_waddr = '0;
  logic [3:0]  tab_wdata = '0;
  logic        start = 1'b0;
  logic [8:0]  txt_len = '0;
  logic        busy, done, cand_valid;
  logic [7:0]  cand_pos;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [7:0] txt_m [256];
  logic [3:0] tab_m [4096];
  int exp_q [$];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  wsk_scanner u0 (
    .clk(clk), .rst_n(rst_n), .txt_we(txt_we), .txt_waddr(txt_waddr),
    .txt_wdata(txt_wdata), .tab_we(tab_we), .tab_waddr(tab_waddr),
    .tab_wdata(tab_wdata), .start(start), .txt_len(txt_len), .busy(busy),
    .done(done), .cand_valid(cand_valid), .cand_pos(cand_pos)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each candidate (R4)
  always @(negedge clk) begin
    if (rst_n && cand_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected candidate", cand_pos, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(cand_pos == e[7:0], "R4 candidate position", cand_pos, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] rnd_letter();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return 8'h41 + {5'd0, lfsr[2:0]};
  endfunction

  task automatic put_txt(input int a, input logic [7:0] d);
    txt_m[a] = d;
    txt_we = 1'b1; txt_waddr = a[7:0]; txt_wdata = d;
    @(negedge clk);
    txt_we = 1'b0;
  endtask

  task automatic fill_tab(input logic [3:0] v);
    for (int i = 0; i < 4096; i++) tab_m[i] = v;
    tab_we = 1'b1; tab_wdata = v;
    for (int i = 0; i < 4096; i++) begin
      tab_waddr = i[11:0];
      @(negedge clk);
    end
    tab_we = 1'b0;
  endtask

  task automatic put_tab(input int a, input logic [3:0] v);
    tab_m[a] = v;
    tab_we = 1'b1; tab_waddr = a[11:0]; tab_wdata = v;
    @(negedge clk);
    tab_we = 1'b0;
  endtask

  // R2: index = upper byte shifted by four, xor lower byte, kept to 12 bits
  function automatic int idx_of(input logic [7:0] a, input logic [7:0] b);
    return ((int'(a) * 16) ^ int'(b)) % 4096;
  endfunction

  // reference walk: pushes expected candidates, returns step count
  function automatic int model(input int len);
    int p = 0;
    int n = 0;
    while (p + 8 <= len) begin
      int s;
      s = int'(tab_m[idx_of(txt_m[p+6], txt_m[p+7])]);
      if (s == 0) begin
        exp_q.push_back(p);
        p = p + 1;
      end else p = p + s;
      n++;
    end
    return n;
  endfunction

  task automatic run_scan(input int len, input bit poke, input string tag);
    int steps;
    int n = 0;
    steps = model(len);
    txt_len = len[8:0];
    start = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      start = (poke && n == 3);
      if (poke && n == 3) txt_len = 9'd0;
      if (done || n > 4000) break;
    end
    start = 1'b0;
    chk(n == 2 * steps + 2, {"R6 done cycle ", tag}, n, 2 * steps + 2);
    chk(!busy, {"R5 idle at done ", tag}, busy, 0);
    chk(exp_q.size() == 0, {"R3 missing candidates ", tag}, exp_q.size(), 0);
    @(negedge clk);
    chk(!done, {"R5 done is one pulse ", tag}, done, 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy, "R1 busy after reset", busy, 0);
    chk(!done, "R1 done after reset", done, 0);
    chk(!cand_valid, "R1 cand after reset", cand_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: uniform maximal shift, no candidates
    for (int i = 0; i < 256; i++) put_txt(i, rnd_letter());
    fill_tab(4'd7);
    run_scan(64, 1'b0, "max-shift");

    // R2 R4: table built for one pattern, pattern planted twice
    begin
      logic [7:0] pat [8];
      for (int k = 0; k < 8; k++) pat[k] = 8'h41 + k[7:0];
      for (int j = 2; j <= 8; j++) begin
        int ix;
        ix = idx_of(pat[j-2], pat[j-1]);
        if (int'(tab_m[ix]) > 8 - j) put_tab(ix, 4'(8 - j));
      end
      for (int k = 0; k < 8; k++) put_txt(20 + k, pat[k]);
      for (int k = 0; k < 8; k++) put_txt(100 + k, pat[k]);
    end
    run_scan(128, 1'b0, "pattern");

    // R5: too short for one window, and exactly one window
    run_scan(5, 1'b0, "short");
    run_scan(0, 1'b0, "empty");
    run_scan(8, 1'b0, "one-window");

    // R7: full buffer with start and length poked mid-scan
    run_scan(256, 1'b1, "poke");

    // R4: zero entry for a repeated byte block: every window is a candidate
    for (int i = 0; i < 40; i++) put_txt(i, 8'h5A);
    put_tab(idx_of(8'h5A, 8'h5A), 4'd0);
    run_scan(40, 1'b0, "all-hit");

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule